// File: doc/BRIEF.md
# Multichannel Slope-Weighted Energy Operator

This block emphasises fast, large excursions in a stream of band-limited neural samples. Samples from many recording sites share one wire: exactly one channel is presented on each accepted clock, and the channels follow a fixed round-robin order. For every accepted sample the block multiplies the sample by its own slope over a fixed lag. The slope is the sample minus the value that the same channel carried a set number of frames earlier. Parts of the signal that are both large and changing quickly come out strongly. Slow or small parts are suppressed. The operator needs one subtraction, one multiplication and a short per-channel history.

The history for every channel is held in an internal store. On each accepted sample, all stored predecessors of the current channel are read at once and the newest sample is pushed in. A warm-up counter keeps the output strobe low until every channel has a full set of predecessors. The result leaves one clock after the input, in the same channel order. The filtering stage upstream and the smoothing and thresholding stages downstream are separate blocks.

Top module: `slope_energy_op`

## Requirements
- R1: For an accepted sample x on channel c, out_data one clock later equals x·(x − p), where p is the sample accepted on channel c exactly LAG frames earlier (LAG defaults to 4). Values are signed two's complement.
- R2: out_valid is high in the clock after an accepted input (in_valid high at a rising edge) once warm-up is complete, and it is low in the clock after any edge where in_valid is low.
- R3: Counting accepted samples from 0 after reset, samples 0 to LAG·NCH−1 give out_valid low. Sample LAG·NCH is the first to give out_valid high.
- R4: Channels are taken in order 0,1,…,NCH−1 and then back to 0. Each result refers to the channel of the sample that produced it.
- R5: Clocks with in_valid low do not advance the channel position, the warm-up count or the history.
- R6: The difference x − p is formed one bit wider than the input, so it never wraps. With the default widths, x = −512 and p = 511 give 523776, and x = 511 and p = −512 give 522753.
- R7: A synchronous reset clears the history and the warm-up count. While reset is held and in the clock after it, out_valid and out_data are 0. After reset, the warm-up of R3 starts again.
- R8: When OUT_W is narrower than the full product width (2·IN_W+1), the result is clamped to the signed OUT_W range. With OUT_W = 16, a product of 523776 gives 32767 and a product of −65280 gives −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample of the current channel |
| out_valid | output | 1 | Energy result strobe |
| out_data | output | OUT_W | Signed energy result |

## Verification
The corner that is hardest to reach from the ports is the pair of extreme products. To reach one, a channel must hold a full-scale sample of one sign for exactly LAG frames, and then receive the full-scale sample of the other sign. The bench fills whole frames with +511 and then, LAG frames later, sends −512 on every channel, and it also runs the mirror case. The same stimulus drives a second instance with a 16-bit output, which is how the clamping is reached. Idle gaps and a reset in the middle of the stream are placed at chosen positions in the frame, so that any change to the channel position or the warm-up count shows up in a later result.

// File: rtl/seo_pkg.sv
package seo_pkg;

   // index width that stays at least one bit wide
   function automatic int idx_w(input int count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

   // full width of x*(x-p) for a signed input of width w
   function automatic int prod_w(input int w);
      return 2 * w + 1;
   endfunction

endpackage

// File: rtl/seo_seq.sv
module seo_seq #(
   parameter int NCH  = 961,
   parameter int LAG  = 4,
   parameter int CH_W = 10,
   parameter int FR_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   output logic [CH_W-1:0] ch,
   output logic            warm
);

   localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);
   localparam logic [FR_W-1:0] FR_FULL = FR_W'(LAG);

   logic [FR_W-1:0] frames;

   always_ff @(posedge clk) begin
      if (rst) begin
         ch     <= '0;
         frames <= '0;
      end else if (adv) begin
         if (ch == CH_LAST) begin
            ch <= '0;
            if (frames != FR_FULL) frames <= frames + 1'b1;
         end else begin
            ch <= ch + 1'b1;
         end
      end
   end

   assign warm = (frames == FR_FULL);

   a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(ch) && $stable(warm)));

   a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
      (adv && ch == CH_LAST) |=> (ch == '0));

   a_r4_step: assert property (@(posedge clk) disable iff (rst)
      (adv && ch != CH_LAST) |=> (ch == $past(ch) + 1'b1));

   a_r3_warm_sticky: assert property (@(posedge clk) disable iff (rst)
      warm |=> warm);

endmodule

// File: rtl/seo_hist.sv
module seo_hist #(
   parameter int NCH  = 961,
   parameter int LAG  = 4,
   parameter int IN_W = 10,
   parameter int CH_W = 10
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [CH_W-1:0]            addr,
   input  logic [IN_W-1:0]            din,
   output logic [LAG-1:0][IN_W-1:0]   taps
);

   localparam int HW = LAG * IN_W;

   logic [HW-1:0] mem [NCH];
   logic [HW-1:0] word;
   logic [HW-1:0] next_word;

   assign word = mem[addr];

   // one read port per lag: tap t holds the sample t+1 frames back
   for (genvar t = 0; t < LAG; t++) begin : g_tap
      assign taps[t] = word[t*IN_W +: IN_W];
   end

   if (LAG == 1) begin : g_single
      assign next_word = din;
   end else begin : g_shift
      assign next_word = {word[HW-IN_W-1:0], din};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NCH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[addr] <= next_word;
      end
   end

   a_r5_newest_tap: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr != '0) |=> (mem[$past(addr)][IN_W-1:0] == $past(din)));

endmodule

// File: rtl/seo_calc.sv
module seo_calc #(
   parameter int IN_W  = 10,
   parameter int OUT_W = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IN_W-1:0]  x,
   input  logic [IN_W-1:0]  past,
   output logic [OUT_W-1:0] energy
);

   localparam int DW = IN_W + 1;
   localparam int PW = seo_pkg::prod_w(IN_W);

   logic signed [DW-1:0] diff;
   logic signed [PW-1:0] prod;

   assign diff = $signed({x[IN_W-1], x}) - $signed({past[IN_W-1], past});
   assign prod = $signed(x) * diff;

   if (OUT_W >= PW) begin : g_full
      assign energy = OUT_W'(prod);
   end else begin : g_clamp
      localparam longint HI = (longint'(1) <<< (OUT_W - 1)) - 1;
      localparam longint LO = -(longint'(1) <<< (OUT_W - 1));
      always_comb begin
         if (longint'(prod) > HI)      energy = {1'b0, {(OUT_W-1){1'b1}}};
         else if (longint'(prod) < LO) energy = {1'b1, {(OUT_W-1){1'b0}}};
         else                          energy = prod[OUT_W-1:0];
      end

      a_r8_sign_kept: assert property (@(posedge clk) disable iff (rst)
         (prod < 0) == (energy[OUT_W-1] == 1'b1));
   end

   a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
      ($signed(x) >= $signed(past)) == (diff >= 0));

endmodule

// File: rtl/slope_energy_op.sv
module slope_energy_op #(
   parameter int NCH   = 961,
   parameter int LAG   = 4,
   parameter int IN_W  = 10,
   parameter int OUT_W = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);

   localparam int CH_W = seo_pkg::idx_w(NCH);
   localparam int FR_W = seo_pkg::idx_w(LAG + 1);

   if (NCH < 2 || LAG < 1 || IN_W < 2 || OUT_W < 2) begin : g_bad_param
      $error("slope_energy_op: parameter out of range");
   end

   logic [CH_W-1:0]          ch;
   logic                     warm;
   logic [LAG-1:0][IN_W-1:0] taps;
   logic [OUT_W-1:0]         energy;

   seo_seq #(.NCH(NCH), .LAG(LAG), .CH_W(CH_W), .FR_W(FR_W)) u_seq (
      .clk  (clk),
      .rst  (rst),
      .adv  (in_valid),
      .ch   (ch),
      .warm (warm)
   );

   seo_hist #(.NCH(NCH), .LAG(LAG), .IN_W(IN_W), .CH_W(CH_W)) u_hist (
      .clk   (clk),
      .rst   (rst),
      .wr_en (in_valid),
      .addr  (ch),
      .din   (in_data),
      .taps  (taps)
   );

   seo_calc #(.IN_W(IN_W), .OUT_W(OUT_W)) u_calc (
      .clk    (clk),
      .rst    (rst),
      .x      (in_data),
      .past   (taps[LAG-1]),
      .energy (energy)
   );

   if (LAG > 1) begin : g_spare_taps
      logic unused_taps;
      assign unused_taps = ^taps[LAG-2:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid && warm;
         if (in_valid) out_data <= energy;
      end
   end

   a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));

   a_r3_cold: assert property (@(posedge clk) disable iff (rst)
      !warm |=> !out_valid);

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_data)));

endmodule

// File: tb/slope_energy_op_bench.sv
module slope_energy_op_bench;

   localparam int NCH = 5;
   localparam int LAG = 4;
   localparam int IN_W = 10;
   localparam int OUT_W = 20;
   localparam int SAT_W = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [IN_W-1:0] in_data = '0;
   logic out_valid, sat_valid;
   logic [OUT_W-1:0] out_data;
   logic [SAT_W-1:0] sat_data;

   int checks = 0;
   int errors = 0;

   int hist [NCH][LAG];
   int ch_m = 0;
   int accepted = 0;
   int seed = 12345;

   always #2.5 clk = ~clk;

   slope_energy_op #(.NCH(NCH), .LAG(LAG), .IN_W(IN_W), .OUT_W(OUT_W)) u_slope_energy_op (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   slope_energy_op #(.NCH(NCH), .LAG(LAG), .IN_W(IN_W), .OUT_W(SAT_W)) u_slope_energy_op_sat (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(sat_valid), .out_data(sat_data));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int clamp16(input int v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic model_clear();
      for (int c = 0; c < NCH; c++)
         for (int k = 0; k < LAG; k++) hist[c][k] = 0;
      ch_m = 0;
      accepted = 0;
   endtask

   // drive one accepted sample and check both instances one clock later
   task automatic push(input int x, input string req);
      int exp, old;
      bit ev;
      old = hist[ch_m][LAG-1];
      exp = x * (x - old);
      ev = (accepted >= LAG * NCH);
      in_valid = 1'b1;
      in_data = IN_W'(x);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, int'(out_valid), int'(ev));
      if (ev) begin
         check({req, " R1 data"}, int'($signed(out_data)), exp);
         check({req, " R8 clamp"}, int'($signed(sat_data)), clamp16(exp));
      end
      for (int k = LAG - 1; k > 0; k--) hist[ch_m][k] = hist[ch_m][k-1];
      hist[ch_m][0] = x;
      ch_m = (ch_m + 1) % NCH;
      accepted++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0;
         @(posedge clk);
         @(negedge clk);
         check("R2/R5 idle no valid", int'(out_valid), 0);
      end
   endtask

   function automatic int rnd();
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 8) & 1023) - 512;
   endfunction

   task automatic t_reset(input string req);
      rst = 1'b1;
      in_valid = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check({req, " reset valid"}, int'(out_valid), 0);
      check({req, " reset data"}, int'(out_data), 0);
      rst = 1'b0;
      model_clear();
      @(negedge clk);
      check({req, " after reset valid"}, int'(out_valid), 0);
   endtask

   task automatic t_warmup();
      for (int i = 0; i < LAG * NCH; i++) push(i * 7 - 60, "R3 warmup");
      push(100, "R3 first valid");
      check("R3 first valid high", int'(out_valid), 1);
   endtask

   task automatic t_order();
      for (int f = 0; f < 2; f++)
         for (int c = 0; c < NCH; c++) push(c * 50 - 100 + f * 3, "R4 order");
   endtask

   task automatic t_random();
      for (int i = 0; i < 60; i++) push(rnd(), "R1 random");
   endtask

   task automatic t_gaps();
      for (int i = 0; i < 3 * NCH * LAG; i++) begin
         push(rnd(), "R5 gaps");
         if (i % 3 == 1) idle(1 + i % 4);
      end
   endtask

   task automatic t_extremes(input int a, input int b, input int exp);
      while (ch_m != 0) push(0, "R6 align");
      for (int c = 0; c < NCH; c++) push(a, "R6 load");
      for (int f = 1; f < LAG; f++)
         for (int c = 0; c < NCH; c++) push(0, "R6 fill");
      for (int c = 0; c < NCH; c++) begin
         push(b, "R6 extreme");
         check("R6 extreme value", int'($signed(out_data)), exp);
         check("R8 extreme clamp", int'($signed(sat_data)), clamp16(exp));
      end
   endtask

   task automatic t_neg_clamp();
      while (ch_m != 0) push(0, "R8 align");
      for (int c = 0; c < NCH; c++) push(511, "R8 load");
      for (int f = 1; f < LAG; f++)
         for (int c = 0; c < NCH; c++) push(0, "R8 fill");
      push(256, "R8 negative");
      check("R8 negative clamp", int'($signed(sat_data)), -32768);
      check("R1 negative full", int'($signed(out_data)), -65280);
   endtask

   task automatic t_mid_reset();
      for (int i = 0; i < 2; i++) push(rnd(), "R7 pre");
      t_reset("R7 mid");
      for (int i = 0; i < LAG * NCH + 2 * NCH; i++) push(rnd(), "R7 rewarm");
   endtask

   initial begin
      model_clear();
      @(negedge clk);
      t_reset("R7 initial");
      t_warmup();
      t_order();
      t_random();
      t_gaps();
      t_extremes(511, -512, 523776);
      t_extremes(-512, 511, 522753);
      t_neg_clamp();
      t_mid_reset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int n = 0; n < 50000; n++) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule